// File: doc/BRIEF.md
# Display Controller Host Register Port

This block is the serial host port of a character display controller. A host processor on a two-wire serial bus (I2C, standard mode up to 100 kHz) addresses the block at a fixed 7-bit device address. It then writes a register subaddress followed by data bytes, or reads bytes back. Eleven control registers (subaddresses 0 to 10) are write-only and appear on a flat configuration bus for the rest of the controller. Subaddress 11 is a window shared by two registers. Writes there always go into a character page memory. Reads there return either the page memory byte or a read-only status byte, depending on a select bit in register 0.

The page memory is reached indirectly through a pointer made of a chapter field (register 8), a row field (register 9) and a column field (register 10). Every memory access through the window moves the column forward. After the last column of a row, the column returns to zero and the row moves on, so the host can stream a whole row of characters in one transfer. The bus lines are sampled with the system clock, which must run much faster than the bus clock. Filtering of line glitches is left to the pads. The memory itself sits outside the block behind a simple port: an address, a one-cycle write strobe and read data that follows the address.

Top module: `dcr_host_port`

## Requirements
- R1: The block acknowledges only the device address 0010001 (address byte 0x22 for a write, 0x23 for a read). Any other address is answered with NACK, and every later byte up to the next START is ignored, so no register or memory changes.
- R2: After each byte received in an addressed transfer (the address byte and every written byte), the block pulls SDA low for exactly the ninth SCL period. It releases SDA before the master places the next bit.
- R3: The first byte after a write address loads the subaddress (values above 11 load 11). Each later byte writes the register at the subaddress and then increments it. The subaddress stops at 11 and keeps that value across transfers.
- R4: After reset, registers 5 and 6 read 0x03 on the configuration bus, all other registers read 0x00, and SDA is not driven.
- R5: Register 8 keeps only bits 2:0 (chapter in bits 1:0), register 9 only bits 4:0 (row) and register 10 only bits 5:0 (column). Upper bits written to these registers are stored as zero.
- R6: A byte written at subaddress 11 produces one clock cycle of memory write. The data is that byte and the address is {chapter, row, column} (chapter in bits 12:11, row in 10:6, column in 5:0). The pointer then steps.
- R7: A pointer step with the column below 39 increments the column. With the column at 39 or above, the step sets the column to 0 and increments the row modulo 32.
- R8: With register 0 bit 0 clear, a byte read at subaddress 11 returns the memory byte at the pointer, and the pointer then steps.
- R9: With register 0 bit 0 set, a byte read at subaddress 11 returns the status byte. Bit 0 is the sync-good input, bit 7 is the 60 Hz input masked by sync-good, and bits 6:1 are zero. The pointer does not move.
- R10: A byte read at a subaddress from 0 to 10 returns 0x00, and each read byte increments the subaddress with the same stop at 11.
- R11: When the master answers a read byte with NACK, the block releases SDA and sends nothing more until the next START.
- R12: The block changes its SDA drive only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| sync_good | input | 1 | Sync quality good, reported in status bit 0 |
| sync_60hz | input | 1 | 60 Hz sync detected, reported in status bit 7 |
| mem_addr | output | 13 | Page memory address {chapter, row, column} |
| mem_we | output | 1 | One-cycle page memory write strobe |
| mem_wdata | output | 8 | Page memory write data |
| mem_rdata | input | 8 | Page memory read data for mem_addr |
| cfg_regs | output | 88 | Registers 0 to 10, register n in bits 8n+7:8n |

## Verification
The checker watches, on every cycle, that the SDA drive changes only while the sampled SCL is low, that each memory write strobe lasts one cycle and is followed by the correct column step or row wrap, and that the pointer registers never hold bits above their field widths. Address matching, acknowledge placement, subaddress loading and its stop at 11, the selection between memory and status on reads, the zero reads at write-only subaddresses and the end of a read on NACK are shown only through the bench's bus transfers. The bench checks these against a model of the register bank and page memory, using both directed transfers and random ones.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int NREG       = 11;
  localparam int REG_W      = 8;
  localparam int SUB_W      = 4;
  localparam int SHARED_SUB = NREG;
  localparam int CHAP_W     = 2;
  localparam int ROW_W      = 5;
  localparam int COL_W      = 6;
  localparam int MADDR_W    = CHAP_W + ROW_W + COL_W;
  localparam int CHAP_REG   = 8;
  localparam int ROW_REG    = 9;
  localparam int COL_REG    = 10;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WBYTE, S_WACK, S_RBYTE, S_RACK
  } bus_st_e;
endpackage

// File: rtl/dcr_line_sync.sv
module dcr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/dcr_bus_fsm.sv
module dcr_bus_fsm
  import dcr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] tx_byte,
  output logic       sda_oe,
  output logic       sub_ld,
  output logic       wr_stb,
  output logic       rd_adv,
  output logic [7:0] rx_byte
);
  bus_st_e    st, st_n;
  logic [3:0] cnt, cnt_n;
  logic [7:0] sh, sh_n, tx, tx_n;
  logic       first, first_n, rd, rd_n, mack, mack_n, drv, drv_n;
  logic       sub_ld_n, wr_stb_n, rd_adv_n;

  always_comb begin
    st_n = st; cnt_n = cnt; sh_n = sh; tx_n = tx;
    first_n = first; rd_n = rd; mack_n = mack; drv_n = drv;
    sub_ld_n = 1'b0; wr_stb_n = 1'b0; rd_adv_n = 1'b0;
    if (stop_det) begin
      st_n = S_IDLE; drv_n = 1'b0;
    end else if (start_det) begin
      st_n = S_ADDR; cnt_n = '0; drv_n = 1'b0;
    end else begin
      case (st)
        S_ADDR, S_WBYTE: begin
          if (scl_rise && cnt != 4'd8) begin
            sh_n  = {sh[6:0], sda_s};
            cnt_n = cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt_n = '0;
            if (st == S_ADDR) begin
              if (sh[7:1] == DEV_ADDR) begin
                st_n = S_AACK; drv_n = 1'b1; rd_n = sh[0]; first_n = 1'b1;
              end else begin
                st_n = S_IDLE;
              end
            end else begin
              st_n = S_WACK; drv_n = 1'b1; first_n = 1'b0;
              if (first) sub_ld_n = 1'b1;
              else       wr_stb_n = 1'b1;
            end
          end
        end
        S_AACK: if (scl_fall) begin
          if (rd) begin
            st_n = S_RBYTE; tx_n = tx_byte; drv_n = ~tx_byte[7]; cnt_n = '0;
          end else begin
            st_n = S_WBYTE; drv_n = 1'b0;
          end
        end
        S_WACK: if (scl_fall) begin
          st_n = S_WBYTE; drv_n = 1'b0;
        end
        S_RBYTE: if (scl_fall) begin
          if (cnt == 4'd7) begin
            st_n = S_RACK; drv_n = 1'b0; rd_adv_n = 1'b1; cnt_n = '0;
          end else begin
            tx_n = {tx[6:0], 1'b0}; drv_n = ~tx[6]; cnt_n = cnt + 4'd1;
          end
        end
        S_RACK: begin
          if (scl_rise) mack_n = ~sda_s;
          else if (scl_fall) begin
            if (mack) begin
              st_n = S_RBYTE; tx_n = tx_byte; drv_n = ~tx_byte[7];
            end else begin
              st_n = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0;
      first <= 1'b0; rd <= 1'b0; mack <= 1'b0; drv <= 1'b0;
      sub_ld <= 1'b0; wr_stb <= 1'b0; rd_adv <= 1'b0;
    end else begin
      st <= st_n; cnt <= cnt_n; sh <= sh_n; tx <= tx_n;
      first <= first_n; rd <= rd_n; mack <= mack_n; drv <= drv_n;
      sub_ld <= sub_ld_n; wr_stb <= wr_stb_n; rd_adv <= rd_adv_n;
    end
  end

  assign sda_oe  = drv;
  assign rx_byte = sh;
endmodule

// File: rtl/dcr_reg_bank.sv
module dcr_reg_bank
  import dcr_pkg::*;
#(
  parameter int COL_LAST = 39
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sub_ld,
  input  logic                   wr_stb,
  input  logic                   rd_adv,
  input  logic [7:0]             rx_byte,
  input  logic                   sync_good,
  input  logic                   sync_60hz,
  input  logic [7:0]             mem_rdata,
  output logic [7:0]             tx_byte,
  output logic [NREG*REG_W-1:0]  cfg_regs,
  output logic [MADDR_W-1:0]     mem_addr,
  output logic                   mem_we,
  output logic [7:0]             mem_wdata
);
  localparam logic [SUB_W-1:0] SHR = SUB_W'(SHARED_SUB);

  logic [NREG-1:0][REG_W-1:0] rf, rf_n;
  logic [SUB_W-1:0] sub, sub_n;
  logic we_n, step;
  logic [7:0] wd_n, status;

  function automatic logic [7:0] fld_mask(input int idx);
    case (idx)
      CHAP_REG: return 8'h07;
      ROW_REG:  return 8'h1F;
      COL_REG:  return 8'h3F;
      default:  return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] rst_val(input int idx);
    return (idx == 5 || idx == 6) ? 8'h03 : 8'h00;
  endfunction

  function automatic logic [SUB_W-1:0] sub_inc(input logic [SUB_W-1:0] s);
    return (s >= SHR) ? SHR : s + SUB_W'(1);
  endfunction

  assign step = mem_we | (rd_adv & (sub == SHR) & ~rf[0][0]);

  always_comb begin
    rf_n = rf; sub_n = sub; we_n = 1'b0; wd_n = mem_wdata;
    if (sub_ld) begin
      sub_n = (rx_byte > 8'(SHARED_SUB)) ? SHR : rx_byte[SUB_W-1:0];
    end else if (wr_stb) begin
      if (sub == SHR) begin
        we_n = 1'b1; wd_n = rx_byte;
      end else begin
        for (int i = 0; i < NREG; i++)
          if (sub == SUB_W'(i)) rf_n[i] = rx_byte & fld_mask(i);
      end
      sub_n = sub_inc(sub);
    end else if (rd_adv) begin
      sub_n = sub_inc(sub);
    end
    if (step) begin
      if (rf[COL_REG][COL_W-1:0] >= COL_W'(COL_LAST)) begin
        rf_n[COL_REG] = '0;
        rf_n[ROW_REG] = {3'b000, rf[ROW_REG][ROW_W-1:0] + 5'd1};
      end else begin
        rf_n[COL_REG] = rf[COL_REG] + 8'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= rst_val(i);
      sub <= '0; mem_we <= 1'b0; mem_wdata <= '0;
    end else begin
      rf <= rf_n; sub <= sub_n; mem_we <= we_n; mem_wdata <= wd_n;
    end
  end

  assign status   = {sync_60hz & sync_good, 6'b000000, sync_good};
  assign tx_byte  = (sub == SHR) ? (rf[0][0] ? status : mem_rdata) : 8'h00;
  assign cfg_regs = rf;
  assign mem_addr = {rf[CHAP_REG][CHAP_W-1:0], rf[ROW_REG][ROW_W-1:0],
                     rf[COL_REG][COL_W-1:0]};
endmodule

// File: rtl/dcr_host_port.sv
module dcr_host_port
  import dcr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h11,
  parameter int         SYNC_STAGES = 2,
  parameter int         COL_LAST    = 39
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic                  sync_good,
  input  logic                  sync_60hz,
  output logic [MADDR_W-1:0]    mem_addr,
  output logic                  mem_we,
  output logic [7:0]            mem_wdata,
  input  logic [7:0]            mem_rdata,
  output logic [NREG*REG_W-1:0] cfg_regs
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic sub_ld, wr_stb, rd_adv;
  logic [7:0] rx_byte, tx_byte;

  dcr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  dcr_bus_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .tx_byte(tx_byte), .sda_oe(sda_oe), .sub_ld(sub_ld), .wr_stb(wr_stb),
    .rd_adv(rd_adv), .rx_byte(rx_byte)
  );

  dcr_reg_bank #(.COL_LAST(COL_LAST)) u_bank (
    .clk(clk), .rst_n(rst_n), .sub_ld(sub_ld), .wr_stb(wr_stb),
    .rd_adv(rd_adv), .rx_byte(rx_byte), .sync_good(sync_good),
    .sync_60hz(sync_60hz), .mem_rdata(mem_rdata), .tx_byte(tx_byte),
    .cfg_regs(cfg_regs), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/dcr_host_port_chk.sv
module dcr_host_port_chk
  import dcr_pkg::*;
#(
  parameter int COL_LAST = 39
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  sda_oe,
  input logic                  mem_we,
  input logic [MADDR_W-1:0]    mem_addr,
  input logic [NREG*REG_W-1:0] cfg_regs
);
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  assign col = mem_addr[COL_W-1:0];
  assign row = mem_addr[COL_W +: ROW_W];

  assert_drive_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_s);

  assert_we_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_col_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && col < COL_W'(COL_LAST)) |=>
      (col == $past(col) + COL_W'(1) && row == $past(row)));

  assert_col_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && col >= COL_W'(COL_LAST)) |=>
      (col == '0 && row == $past(row) + ROW_W'(1)));

  assert_field_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_regs[CHAP_REG*8+7:CHAP_REG*8+3] == '0) &&
    (cfg_regs[ROW_REG*8+7:ROW_REG*8+5] == '0) &&
    (cfg_regs[COL_REG*8+7:COL_REG*8+6] == '0));
endmodule

bind dcr_host_port dcr_host_port_chk #(.COL_LAST(COL_LAST)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .mem_we(mem_we), .mem_addr(mem_addr), .cfg_regs(cfg_regs)
);

// File: tb/dcr_host_port_tb.sv
module dcr_host_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int WD_CYCLES = 190000;
  localparam logic [6:0] DEV = 7'h11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sync_good = 1'b0, sync_60hz = 1'b0;
  logic [12:0] mem_addr;
  logic mem_we;
  logic [7:0] mem_wdata, mem_rdata = 8'h20;
  logic [87:0] cfg_regs;
  logic sda_line;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] ram [int];
  logic [7:0] mmem [int];
  logic [7:0] er [0:10];
  logic [3:0] esub;
  logic [7:0] wbuf [0:7];
  int line_err;

  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcr_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .sync_good(sync_good), .sync_60hz(sync_60hz), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cfg_regs(cfg_regs)
  );

  always @(negedge clk) begin
    if (mem_we) ram[int'(mem_addr)] = mem_wdata;
    mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h20;
  end

  task automatic chk(input bit ok, input string req, input logic [87:0] act,
                     input logic [87:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- model ----------------
  function automatic logic [7:0] mask_of(input int i);
    if (i == 8) return 8'h07;
    if (i == 9) return 8'h1F;
    if (i == 10) return 8'h3F;
    return 8'hFF;
  endfunction

  function automatic int m_addr();
    return int'({er[8][1:0], er[9][4:0], er[10][5:0]});
  endfunction

  task automatic m_step();
    if (er[10][5:0] >= 6'd39) begin
      er[10] = 8'h00;
      er[9] = {3'b000, er[9][4:0] + 5'd1};
    end else er[10] = er[10] + 8'd1;
  endtask

  function automatic logic [3:0] m_inc(input logic [3:0] s);
    return (s >= 4'd11) ? 4'd11 : s + 4'd1;
  endfunction

  task automatic m_write(input logic [7:0] b);
    if (esub == 4'd11) begin
      mmem[m_addr()] = b;
      m_step();
    end else er[esub] = b & mask_of(int'(esub));
    esub = m_inc(esub);
  endtask

  task automatic m_read(output logic [7:0] v);
    if (esub == 4'd11) begin
      if (er[0][0]) v = {sync_60hz & sync_good, 6'b0, sync_good};
      else begin
        v = mmem.exists(m_addr()) ? mmem[m_addr()] : 8'h20;
        m_step();
      end
    end else v = 8'h00;
    esub = m_inc(esub);
  endtask

  function automatic logic [87:0] m_cfg();
    logic [87:0] r;
    for (int i = 0; i < 11; i++) r[i*8 +: 8] = er[i];
    return r;
  endfunction

  // ---------------- bus master ----------------
  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wq(); sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic bus_bit(input logic b, output logic s, output logic s_early);
    wq(); sda_m = b; wq(); scl_m = 1'b1;
    repeat (2) @(negedge clk); s_early = sda_line;
    repeat (Q-2) @(negedge clk); s = sda_line;
    wq(); scl_m = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s, e;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(b[i], s, e);
      if (s !== b[i]) line_err++;
    end
    bus_bit(1'b1, s, e);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] v);
    logic s, e;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s, e);
      v[i] = s;
      if (s !== e) line_err++;
    end
    bus_bit(~give_ack, s, e);
  endtask

  // write transfer: subaddress, then n bytes from wbuf
  task automatic wr_txn(input logic [7:0] sa, input int n, input string req);
    logic ack;
    int nacks = 0;
    line_err = 0;
    bus_start();
    wr_byte({DEV, 1'b0}, ack); if (!ack) nacks++;
    wr_byte(sa, ack); if (!ack) nacks++;
    esub = (sa > 8'd11) ? 4'd11 : sa[3:0];
    for (int i = 0; i < n; i++) begin
      wr_byte(wbuf[i], ack); if (!ack) nacks++;
      m_write(wbuf[i]);
    end
    bus_stop();
    chk(nacks == 0 && line_err == 0, "R2", 88'(nacks), 88'(0));
    chk(cfg_regs === m_cfg(), req, cfg_regs, m_cfg());
  endtask

  task automatic rd_txn(input int n, input string req);
    logic ack;
    logic [7:0] v, e;
    line_err = 0;
    bus_start();
    wr_byte({DEV, 1'b1}, ack);
    chk(ack, "R1", 88'(ack), 88'(1));
    for (int i = 0; i < n; i++) begin
      m_read(e);
      rd_byte(i != n-1, v);
      chk(v === e, req, 88'(v), 88'(e));
    end
    bus_stop();
    chk(line_err == 0, "R12", 88'(line_err), 88'(0));
    chk(sda_oe == 1'b0, "R11", 88'(sda_oe), 88'(0));
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] v;
    void'($urandom(32'd4242));
    for (int i = 0; i < 11; i++) er[i] = (i == 5 || i == 6) ? 8'h03 : 8'h00;
    esub = 4'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R4 reset state
    chk(cfg_regs === m_cfg(), "R4", cfg_regs, m_cfg());
    chk(sda_oe == 1'b0, "R4", 88'(sda_oe), 88'(0));

    // R1 wrong address: NACK and ignored
    bus_start();
    wr_byte({7'h12, 1'b0}, ack);
    chk(!ack, "R1", 88'(ack), 88'(0));
    wr_byte(8'h05, ack);
    wr_byte(8'hAA, ack);
    bus_stop();
    chk(cfg_regs === m_cfg(), "R1", cfg_regs, m_cfg());

    // R3 burst to registers 0..7
    for (int i = 0; i < 8; i++) wbuf[i] = 8'h10 + 8'(i * 17);
    wbuf[0] = 8'h00;
    wr_txn(8'h00, 8, "R3");

    // R5 field widths
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF;
    wr_txn(8'h08, 3, "R5");

    // R6/R7 pointer at chapter 1 row 3 col 38, three bytes through the window
    wbuf[0] = 8'h01; wbuf[1] = 8'h03; wbuf[2] = 8'h26;
    wbuf[3] = 8'h41; wbuf[4] = 8'h42; wbuf[5] = 8'h43;
    wr_txn(8'h08, 6, "R7");
    chk(cfg_regs[79:72] === 8'h04 && cfg_regs[87:80] === 8'h01, "R7",
        cfg_regs[87:72], 88'h0104);
    chk(ram.exists(int'({2'd1, 5'd3, 6'd38})) && ram[int'({2'd1, 5'd3, 6'd38})] === 8'h41 &&
        ram[int'({2'd1, 5'd3, 6'd39})] === 8'h42 && ram[int'({2'd1, 5'd4, 6'd0})] === 8'h43,
        "R6", 88'(ram.size()), 88'(3));

    // R8 read back through the window, beyond written bytes shows 0x20
    wbuf[0] = 8'h03; wbuf[1] = 8'h26;
    wr_txn(8'h09, 2, "R3");
    rd_txn(4, "R8");
    chk(cfg_regs[87:80] === 8'h02, "R8", 88'(cfg_regs[87:80]), 88'h02);

    // R9 status view, pointer unchanged
    wbuf[0] = 8'h01;
    wr_txn(8'h00, 1, "R3");
    wr_txn(8'h0E, 0, "R3");
    sync_good = 1'b1; sync_60hz = 1'b1; rd_txn(2, "R9");
    sync_good = 1'b0; sync_60hz = 1'b1; rd_txn(1, "R9");
    sync_good = 1'b1; sync_60hz = 1'b0; rd_txn(1, "R9");
    chk(cfg_regs === m_cfg() && cfg_regs[87:80] === 8'h02, "R9", cfg_regs, m_cfg());

    // R10 reads at write-only subaddresses return zero and advance
    wr_txn(8'h09, 0, "R10");
    rd_txn(3, "R10");

    // R11 after NACK no more data: a second read still works
    bus_start();
    wr_byte({DEV, 1'b1}, ack);
    m_read(v);
    rd_byte(1'b0, v);
    repeat (3 * Q) @(negedge clk);
    chk(sda_oe == 1'b0, "R11", 88'(sda_oe), 88'(0));
    bus_stop();

    // random mix
    for (int it = 0; it < 24; it++) begin
      int n;
      n = 1 + int'($urandom % 5);
      if ($urandom % 2 == 0) begin
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        if ($urandom % 3 == 0) wbuf[0] = {7'b0, wbuf[0][0]};
        wr_txn(8'($urandom % 14), n, "R3");
      end else begin
        sync_good = 1'($urandom); sync_60hz = 1'($urandom);
        rd_txn(n, "R8");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule